// File: doc/BRIEF.md
# Gated one-shot and square-wave pulse generator

This block is a fully synchronous multivibrator. A single down-counter, run from the system clock, sets every time interval. It has two uses. First, it can act as a gated free-running square-wave source with a faster oscillator tap. Second, it can act as an edge-triggered one-shot. The trigger edge is selectable, and the pulse can be stretched by retrigger pulses. Two parameters, both counted in clock cycles, set the timing: `HALF_A` is one half-period of the square wave, and `TM` is the one-shot width.

Every control input may change at any time. Each input first passes through a two-flop synchronizer. Edges are then found by comparing the synchronized value with its value one cycle earlier. The counter acts on a pin change at the third rising clock edge after that change. The master reset input is the one exception for the outputs. It blanks the outputs at once through combinational gating. It also clears the internal state once it has been synchronized.

The square-wave mode takes priority over one-shot triggering. While either enable is active, trigger edges have no effect. When both enables are inactive, a pin change reaches the counter through the same synchronizer latency described above.

Top module: `gated_multivibrator`

## Requirements
- R1: While `rst_n` is low, `q` is 0, `q_n` is 1 and `osc` is 0.
- R2: `q_n` is the exact inverse of `q` in every cycle, including while `mreset` is high.
- R3: A change on any control pin affects the internal state at the third rising clock edge after the change. For example, a trigger set just after edge k raises `q` right after edge k+3.
- R4: Square-wave mode is active while the synchronized `run_hi` is 1 or the synchronized `run_lo_n` is 0. When both are inactive, square-wave output stops and `q` and `osc` go to 0 at the next clock edge.
- R5: When square-wave mode starts, `q` is 1 for the first `TM` cycles. After that it toggles every `HALF_A` cycles, giving an equal high and low time of `HALF_A` cycles each.
- R6: In square-wave mode, `osc` is 1 exactly when the number of cycles left in the current half-cycle of `q` is greater than floor(`HALF_A`/2), counting the present cycle. This gives `osc` a period of `HALF_A` cycles, half the period of `q`. In the other modes `osc` is 0.
- R7: With `trig_fall` at 0, a rising edge on `trig_rise` starts a one-shot pulse. `q` is then 1 for exactly `TM` cycles.
- R8: With `trig_rise` at 1, a falling edge on `trig_fall` starts the same `TM`-cycle pulse.
- R9: The pulse width does not depend on how long the trigger is held. A trigger edge without a retrigger edge during a running pulse is ignored.
- R10: A rising edge on `retrig` in the same cycle as a rising edge on `trig_rise` restarts the timing. The pulse then ends `TM` cycles after the last such edge. Two retrigger pulses spaced closer than `TM` therefore give a longer pulse than one.
- R11: While square-wave mode is active, edges on `trig_rise`, `trig_fall` and `retrig` have no effect on `q` or `osc`.
- R12: While `mreset` is high, `q` and `osc` are 0 in the same cycle. After synchronization it clears the counter, so any pulse in progress is lost. If square-wave mode is still enabled on release, it restarts with a first half-cycle of `TM`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_hi | input | 1 | Square-wave enable, active high |
| run_lo_n | input | 1 | Square-wave enable, active low |
| trig_rise | input | 1 | One-shot trigger on its rising edge |
| trig_fall | input | 1 | One-shot trigger on its falling edge |
| retrig | input | 1 | Retrigger, used together with `trig_rise` |
| mreset | input | 1 | Master reset: blanks outputs and clears timing |
| q | output | 1 | Pulse / square-wave output |
| q_n | output | 1 | Complement of `q` |
| osc | output | 1 | Oscillator tap at twice the square-wave rate |

## Verification
The bench builds the block with `HALF_A` = 6 and `TM` = 9. With these values many square-wave half-cycles fit into each short random episode, and the odd first half-cycle cannot be confused with a regular one. The `osc` split falls on a clean three-cycle boundary. A `TM` of 9 also lets retrigger pulses spaced five cycles apart overlap the running pulse, so pulse stretching and the last-cycle reload are both exercised within a few dozen cycles.

// File: rtl/gmv_pkg.sv
package gmv_pkg;

  typedef enum logic [1:0] {
    MD_IDLE = 2'd0,
    MD_SHOT = 2'd1,
    MD_ASTB = 2'd2
  } gmv_mode_t;

  // positions of the control pins inside the synchronized vector
  localparam int PIN_N    = 6;
  localparam int PIN_RUNH = 0;
  localparam int PIN_RUNL = 1;
  localparam int PIN_TP   = 2;
  localparam int PIN_TM   = 3;
  localparam int PIN_RT   = 4;
  localparam int PIN_MR   = 5;

  // inactive level of every pin, used as synchronizer reset value
  localparam logic [PIN_N-1:0] PIN_IDLE = 6'b000010;

  // counter width able to hold the larger of two cycle counts
  function automatic int cnt_bits(int a, int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

  // oscillator tap: high while more than half/2 cycles remain in the half-cycle
  function automatic logic osc_high(int left, int half);
    return left >= (half / 2);
  endfunction

endpackage

// File: rtl/gmv_sync.sv
module gmv_sync #(
  parameter int              W      = 1,
  parameter int              STAGES = 2,
  parameter logic [W-1:0]    RSTV   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RSTV;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/gmv_events.sv
module gmv_events
  import gmv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIN_N-1:0] s,
  output logic             act,
  output logic             clr,
  output logic             trig,
  output logic             rtrig
);

  logic pv_tp, pv_tm, pv_rt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_tp <= PIN_IDLE[PIN_TP];
      pv_tm <= PIN_IDLE[PIN_TM];
      pv_rt <= PIN_IDLE[PIN_RT];
    end else begin
      pv_tp <= s[PIN_TP];
      pv_tm <= s[PIN_TM];
      pv_rt <= s[PIN_RT];
    end
  end

  // named edge events
  logic tp_rise, tm_fall, rt_rise, pos_trig, neg_trig;
  assign tp_rise  = s[PIN_TP] & ~pv_tp;
  assign tm_fall  = pv_tm & ~s[PIN_TM];
  assign rt_rise  = s[PIN_RT] & ~pv_rt;
  assign pos_trig = tp_rise & ~s[PIN_TM];
  assign neg_trig = tm_fall & s[PIN_TP];

  assign act   = s[PIN_RUNH] | ~s[PIN_RUNL];
  assign clr   = s[PIN_MR];
  assign trig  = pos_trig | neg_trig;
  assign rtrig = tp_rise & rt_rise;

endmodule

// File: rtl/gmv_core.sv
module gmv_core
  import gmv_pkg::*;
#(
  parameter int HALF_A = 50,
  parameter int TM     = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act,
  input  logic clr,
  input  logic trig,
  input  logic rtrig,
  output logic q_st,
  output logic osc_st
);

  localparam int            CW    = cnt_bits(TM, HALF_A);
  localparam logic [CW-1:0] TM_LD = CW'(TM - 1);
  localparam logic [CW-1:0] HA_LD = CW'(HALF_A - 1);

  gmv_mode_t     mode, mode_d;
  logic [CW-1:0] cnt, cnt_d;
  logic          q_r, q_d;

  // named internal events
  logic cnt_zero, ast_start, ast_flip, ast_stop, shot_start, shot_reload, shot_end;
  assign cnt_zero    = (cnt == '0);
  assign ast_start   = ~clr & act & (mode != MD_ASTB);
  assign ast_flip    = ~clr & act & (mode == MD_ASTB) & cnt_zero;
  assign ast_stop    = ~clr & ~act & (mode == MD_ASTB);
  assign shot_start  = ~clr & ~act & (mode == MD_IDLE) & trig;
  assign shot_reload = ~clr & ~act & (mode == MD_SHOT) & rtrig;
  assign shot_end    = ~clr & ~act & (mode == MD_SHOT) & ~rtrig & cnt_zero;

  always_comb begin
    mode_d = mode;
    cnt_d  = cnt;
    q_d    = q_r;
    if (clr) begin
      mode_d = MD_IDLE;
      cnt_d  = '0;
      q_d    = 1'b0;
    end else if (ast_start) begin
      mode_d = MD_ASTB;
      cnt_d  = TM_LD;
      q_d    = 1'b1;
    end else if (ast_flip) begin
      cnt_d = HA_LD;
      q_d   = ~q_r;
    end else if (mode == MD_ASTB && act) begin
      cnt_d = cnt - 1'b1;
    end else if (ast_stop) begin
      mode_d = MD_IDLE;
      cnt_d  = '0;
      q_d    = 1'b0;
    end else if (shot_start || shot_reload) begin
      mode_d = MD_SHOT;
      cnt_d  = TM_LD;
      q_d    = 1'b1;
    end else if (shot_end) begin
      mode_d = MD_IDLE;
      q_d    = 1'b0;
    end else if (mode == MD_SHOT) begin
      cnt_d = cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MD_IDLE;
      cnt  <= '0;
      q_r  <= 1'b0;
    end else begin
      mode <= mode_d;
      cnt  <= cnt_d;
      q_r  <= q_d;
    end
  end

  assign q_st   = q_r;
  assign osc_st = (mode == MD_ASTB) && osc_high(32'(cnt), HALF_A);

  // R4: dropping both enables stops the square wave on the next edge
  p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && !clr && mode == MD_ASTB) |=> (!q_r && mode == MD_IDLE));

  // R5: square-wave start opens a TM-long high half-cycle
  p_first_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !clr && mode != MD_ASTB) |=> (q_r && mode == MD_ASTB && cnt == TM_LD));

  // R5: an expired half-cycle flips q and reloads the half period
  p_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !clr && mode == MD_ASTB && cnt == '0) |=> (q_r != $past(q_r) && cnt == HA_LD));

  // R11: trigger activity cannot pull the block out of square-wave mode
  p_ast_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !clr && mode == MD_ASTB) |=> (mode == MD_ASTB));

  // R9: a running pulse counts down undisturbed by plain trigger edges
  p_shot_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SHOT && !act && !clr && !rtrig && cnt != '0) |=> (q_r && cnt == $past(cnt) - 1'b1));

  // R10: a retrigger during a pulse restores the full width
  p_retrig_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_SHOT && !act && !clr && rtrig) |=> (q_r && cnt == TM_LD));

  // R12: synchronized master reset empties the timing state
  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (mode == MD_IDLE && !q_r && cnt == '0));

endmodule

// File: rtl/gated_multivibrator.sv
module gated_multivibrator
  import gmv_pkg::*;
#(
  parameter int HALF_A = 50,
  parameter int TM     = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_hi,
  input  logic run_lo_n,
  input  logic trig_rise,
  input  logic trig_fall,
  input  logic retrig,
  input  logic mreset,
  output logic q,
  output logic q_n,
  output logic osc
);

  logic [PIN_N-1:0] raw, s;
  logic act, clr, trig, rtrig, q_st, osc_st;

  assign raw = {mreset, retrig, trig_fall, trig_rise, run_lo_n, run_hi};

  gmv_sync #(.W(PIN_N), .STAGES(2), .RSTV(PIN_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(s)
  );

  gmv_events u_events (
    .clk(clk), .rst_n(rst_n), .s(s),
    .act(act), .clr(clr), .trig(trig), .rtrig(rtrig)
  );

  gmv_core #(.HALF_A(HALF_A), .TM(TM)) u_core (
    .clk(clk), .rst_n(rst_n), .act(act), .clr(clr), .trig(trig), .rtrig(rtrig),
    .q_st(q_st), .osc_st(osc_st)
  );

  // master reset blanks the outputs without waiting for the synchronizer
  assign q   = q_st & ~mreset;
  assign q_n = ~q;
  assign osc = osc_st & ~mreset;

  // R12: once synchronized reset has been seen for a cycle, no output is high
  p_mr_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!q && !osc));

endmodule

// File: tb/tb_gated_multivibrator.sv
`timescale 1ns/1ps
module tb_gated_multivibrator;

  localparam int HA  = 6;
  localparam int TMW = 9;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, run_hi, run_lo_n, trig_rise, trig_fall, retrig, mreset;
  logic q, q_n, osc;

  gated_multivibrator #(.HALF_A(HA), .TM(TMW)) dut (
    .clk(clk), .rst_n(rst_n), .run_hi(run_hi), .run_lo_n(run_lo_n),
    .trig_rise(trig_rise), .trig_fall(trig_fall), .retrig(retrig),
    .mreset(mreset), .q(q), .q_n(q_n), .osc(osc)
  );

  int    total = 0;
  int    bad   = 0;
  int    hi_cnt = 0;
  string tag = "";
  bit    cmp_on = 0;
  bit    done = 0;

  task automatic chk(bit ok, string rq, string what, int a, int e);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, a, e);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // square-wave shape t cycles after the start edge (R5)
  function automatic bit exp_ast_q(int t);
    if (t < TMW) return 1'b1;
    return (((t - TMW) / HA) % 2) == 1;
  endfunction

  // oscillator tap t cycles after the start edge (R6)
  function automatic bit exp_ast_osc(int t);
    int left;
    if (t < TMW) left = TMW - t;
    else         left = HA - ((t - TMW) % HA);
    return 2 * left > 2 * (HA / 2) + 1 || left > HA / 2;
  endfunction

  // reference model: pin pipeline with timestamps
  bit [5:0] s1, s2, pv;
  int n, m_mode, m_end, m_start;
  bit eq, eo;

  always begin
    bit act, clr, tpr, trr, tmf, trg, rtg;
    @(posedge clk);
    if (!rst_n) begin
      s1 = 6'b000010; s2 = 6'b000010; pv = 6'b000010;
      m_mode = 0; n = 0; eq = 0; eo = 0;
    end else begin
      act = s2[0] | ~s2[1];
      clr = s2[5];
      tpr = s2[2] & ~pv[2];
      trr = s2[4] & ~pv[4];
      tmf = pv[3] & ~s2[3];
      trg = (tpr & ~s2[3]) | (tmf & s2[2]);
      rtg = tpr & trr;
      if (clr) m_mode = 0;
      else if (act) begin
        if (m_mode != 2) begin m_mode = 2; m_start = n; end
      end
      else if (m_mode == 2) m_mode = 0;
      else if (m_mode == 0) begin
        if (trg) begin m_mode = 1; m_end = n + TMW; end
      end
      else begin
        if (rtg) m_end = n + TMW;
        else if (n == m_end) m_mode = 0;
      end
      case (m_mode)
        1:       begin eq = 1; eo = 0; end
        2:       begin eq = exp_ast_q(n - m_start); eo = exp_ast_osc(n - m_start); end
        default: begin eq = 0; eo = 0; end
      endcase
      pv = s2; s2 = s1;
      s1 = {mreset, retrig, trig_fall, trig_rise, run_lo_n, run_hi};
      n++;
    end
    #1;
    if (cmp_on && rst_n) begin
      chk(q == (eq & ~mreset), (tag != "") ? tag : ((m_mode == 2) ? "R5" : "R7"), "q", q, eq & ~mreset);
      chk(osc == (eo & ~mreset), (tag != "") ? tag : "R6", "osc", osc, eo & ~mreset);
      chk(q_n == ~q, "R2", "q_n", q_n, ~q);
      if (q) hi_cnt++;
    end
  end

  task automatic cyc(int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; run_hi = 0; run_lo_n = 1; trig_rise = 0; trig_fall = 0; retrig = 0; mreset = 0;
    void'($urandom(32'd4047));
    cyc(4);
    chk(q == 0 && q_n == 1 && osc == 0, "R1", "reset outputs q", q, 0);
    rst_n = 1; cmp_on = 1;
    cyc(4);

    // R3 latency and R9 long trigger
    tag = "R3";
    trig_rise = 1;
    @(posedge clk); #2; chk(q == 0, "R3", "q after edge1", q, 0);
    @(posedge clk); #2; chk(q == 0, "R3", "q after edge2", q, 0);
    @(posedge clk); #2; chk(q == 1, "R3", "q after edge3", q, 1);
    tag = "R9"; hi_cnt = 1;
    cyc(30);
    chk(hi_cnt == TMW, "R9", "width with long trigger", hi_cnt, TMW);
    trig_rise = 0; cyc(6);

    // R9 second trigger edge during pulse ignored
    hi_cnt = 0;
    trig_rise = 1; cyc(1); trig_rise = 0; cyc(2); trig_rise = 1; cyc(1); trig_rise = 0;
    cyc(20);
    chk(hi_cnt == TMW, "R9", "width with extra edge", hi_cnt, TMW);

    // R8 negative-edge trigger
    tag = "R8"; hi_cnt = 0;
    trig_fall = 1; cyc(2); trig_rise = 1; cyc(8);
    chk(hi_cnt == 0, "R8", "no pulse from plus edge with minus high", hi_cnt, 0);
    trig_fall = 0; cyc(20);
    chk(hi_cnt == TMW, "R8", "falling-edge width", hi_cnt, TMW);
    trig_rise = 0; cyc(4);

    // R10 retrigger chain spaced 5 cycles
    tag = "R10"; hi_cnt = 0;
    for (int i = 0; i < 4; i++) begin
      trig_rise = 1; retrig = 1; cyc(1); trig_rise = 0; retrig = 0; cyc(4);
    end
    cyc(20);
    chk(hi_cnt == 3 * 5 + TMW, "R10", "stretched width", hi_cnt, 3 * 5 + TMW);

    // R4/R5/R6/R11 square wave via active-low enable with trigger noise
    tag = "R11";
    run_lo_n = 0;
    for (int i = 0; i < 60; i++) begin
      cyc(1);
      if (i % 7 == 3) trig_rise = ~trig_rise;
      if (i % 11 == 5) begin trig_fall = ~trig_fall; retrig = ~retrig; end
    end
    trig_rise = 0; trig_fall = 0; retrig = 0;
    tag = "R4";
    run_lo_n = 1; cyc(4);
    chk(q == 0 && osc == 0, "R4", "gated off", q, 0);
    tag = "R5";
    run_hi = 1; cyc(45);

    // R12 immediate blanking and restart
    tag = "R12";
    while (q != 1) cyc(1);
    mreset = 1; #1;
    chk(q == 0 && osc == 0 && q_n == 1, "R12", "immediate blank", q, 0);
    cyc(4); mreset = 0; cyc(30);
    run_hi = 0; cyc(5);
    trig_rise = 1; cyc(5); mreset = 1; cyc(1); mreset = 0; cyc(3);
    chk(q == 0, "R12", "pulse lost after reset", q, 0);
    trig_rise = 0; cyc(12);

    // constrained random episodes
    tag = "";
    for (int seg = 0; seg < 30; seg++) begin
      int kind;
      kind = $urandom % 3;
      if (kind == 1) begin
        if ($urandom % 2) run_hi = 1; else run_lo_n = 0;
      end
      for (int c = 0; c < 50; c++) begin
        cyc(1);
        if ($urandom % 8 == 0) begin
          trig_rise = ~trig_rise;
          retrig = trig_rise ? 1'($urandom % 2) : 1'b0;
        end
        if ($urandom % 10 == 0) trig_fall = ~trig_fall;
        if (kind == 2) mreset = ($urandom % 20 == 0);
      end
      run_hi = 0; run_lo_n = 1; mreset = 0;
      cyc(3);
    end
    cyc(20);
    cmp_on = 0; done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule